// File: doc/BRIEF.md
# Contiguous Buffer Bank Allocator

The allocator hands out a shared buffer region split into four equal banks. A requester gives a byte length. The block works out how many banks that length needs and picks the lowest-starting run of that many adjacent free banks. It marks those banks busy and replies with a bank mask and the byte offset of the first bank in the run. A separate free port returns banks by mask. The free port has no handshake and takes effect in the cycle it is presented.

One allocation request is accepted per cycle through a valid/ready pair. Each accepted request gets exactly one response, which comes out the next cycle. The response is held until it is taken, and no new request is accepted while a response waits. The busy bitmap is visible at all times. The buffer memory and the data copy are not part of the block.

Top module: `span_bank_alloc`

## Requirements
- R1: During and after reset the busy bitmap is all zero, no response is pending, and the allocation port is ready.
- R2: A request whose length is greater than the total buffer length gets error code 2 (length error), a zero mask, and leaves the bitmap unchanged.
- R3: A zero-length request gets error code 0, mask 0 and offset 0, and marks no bank busy.
- R4: The number of banks granted is the smallest count whose combined size covers the length. The banks form one adjacent run, and the run starts at the lowest bank index where enough adjacent banks are free. Mask bit i stands for bank i.
- R5: When no run of enough adjacent free banks exists, the response carries error code 1 (no buffer) and a zero mask, and the bitmap is unchanged.
- R6: The offset of a successful grant equals the index of the lowest mask bit times the bank size, where the bank size is one quarter of the total length.
- R7: A free clears exactly the busy bits set in its mask. A zero mask changes nothing.
- R8: When an allocation is accepted in the same cycle as a free, the free is applied first, so the allocation can use the banks being released.
- R9: The response appears in the cycle after acceptance and stays stable while its ready is low. The request port is not ready while an untaken response is pending.
- R10: Error codes are 0 for success, 1 for no buffer and 2 for length error. A successful grant sets the busy bits of its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_ready | output | 1 | Allocation request can be accepted |
| alloc_len | input | LEN_W | Requested length in bytes |
| free_valid | input | 1 | Free request present |
| free_mask | input | NUM_BANKS | Banks to release |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response taken |
| rsp_mask | output | NUM_BANKS | Granted banks |
| rsp_offset | output | OFF_W | Byte offset of the first granted bank |
| rsp_err | output | 2 | Result code |
| busy_map | output | NUM_BANKS | Current busy bitmap |

## Verification
The properties assume that callers free only banks they were granted. Under that assumption the bitmap can never lose bits that a pending grant still relies on. The assumption matters most when a free collides with an allocation in the same cycle. The stimulus therefore frees masks taken from earlier expected grants, or whole ranges that the expected bitmap shows as busy. It also holds the request steady while backpressure is applied, so the checks against a stable response and an unchanged bitmap are meaningful.

// File: rtl/span_alloc_pkg.sv
package span_alloc_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NOBUF   = 2'd1,
    RES_TOOLONG = 2'd2
  } alloc_res_e;
endpackage

// File: rtl/span_need_calc.sv
module span_need_calc #(
  parameter int TOTAL_BYTES = 4096,
  parameter int NUM_BANKS   = 4,
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 3
) (
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] need,
  output logic             too_long
);
  localparam int BANK_BYTES = TOTAL_BYTES / NUM_BANKS;

  // a bank k is needed when the length reaches past k full banks
  always_comb begin
    need = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (len > LEN_W'(k * BANK_BYTES)) need = need + CNT_W'(1);
    end
    too_long = (len > LEN_W'(TOTAL_BYTES));
  end
endmodule

// File: rtl/span_first_fit.sv
module span_first_fit #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 3,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS-1:0] busy,
  input  logic [CNT_W-1:0]     need,
  output logic                 found,
  output logic [NUM_BANKS-1:0] mask,
  output logic [IDX_W-1:0]     start
);
  logic [NUM_BANKS-1:0] win [NUM_BANKS];
  logic [NUM_BANKS-1:0] fit;

  for (genvar s = 0; s < NUM_BANKS; s++) begin : g_start
    always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        win[s][b] = (b >= s) && (b < s + int'(need));
      end
      fit[s] = (need != '0) && (s + int'(need) <= NUM_BANKS) &&
               ((win[s] & busy) == '0);
    end
  end

  // walk downward so the lowest fitting start is the last one written
  always_comb begin
    found = 1'b0;
    mask  = '0;
    start = '0;
    for (int s = NUM_BANKS - 1; s >= 0; s--) begin
      if (fit[s]) begin
        found = 1'b1;
        mask  = win[s];
        start = IDX_W'(s);
      end
    end
  end
endmodule

// File: rtl/span_bank_alloc.sv
module span_bank_alloc
  import span_alloc_pkg::*;
#(
  parameter int TOTAL_BYTES = 4096,
  parameter int NUM_BANKS   = 4,
  parameter int LEN_W       = 16,
  parameter int OFF_W       = $clog2(TOTAL_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  output logic                 alloc_ready,
  input  logic [LEN_W-1:0]     alloc_len,
  input  logic                 free_valid,
  input  logic [NUM_BANKS-1:0] free_mask,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [NUM_BANKS-1:0] rsp_mask,
  output logic [OFF_W-1:0]     rsp_offset,
  output logic [1:0]           rsp_err,
  output logic [NUM_BANKS-1:0] busy_map
);
  localparam int BANK_BYTES = TOTAL_BYTES / NUM_BANKS;
  localparam int CNT_W      = $clog2(NUM_BANKS + 1);
  localparam int IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_BANKS-1:0] busy_q, busy_d, busy_freed;
  logic                 rv_q, rv_d;
  logic [NUM_BANKS-1:0] rmask_q, rmask_d;
  logic [OFF_W-1:0]     roff_q, roff_d;
  alloc_res_e           rerr_q, rerr_d;
  logic                 fire;
  logic [CNT_W-1:0]     need;
  logic                 too_long, found;
  logic [NUM_BANKS-1:0] fit_mask;
  logic [IDX_W-1:0]     fit_start;

  assign alloc_ready = ~rv_q | rsp_ready;
  assign fire        = alloc_valid & alloc_ready;
  assign busy_freed  = busy_q & ~(free_valid ? free_mask : '0);

  span_need_calc #(
    .TOTAL_BYTES(TOTAL_BYTES), .NUM_BANKS(NUM_BANKS),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_need (
    .len(alloc_len), .need(need), .too_long(too_long)
  );

  span_first_fit #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_fit (
    .busy(busy_freed), .need(need), .found(found),
    .mask(fit_mask), .start(fit_start)
  );

  // next-state: frees land before the grant is searched
  always_comb begin
    busy_d  = busy_freed;
    rv_d    = rv_q & ~rsp_ready;
    rmask_d = rmask_q;
    roff_d  = roff_q;
    rerr_d  = rerr_q;
    if (fire) begin
      rv_d    = 1'b1;
      rmask_d = '0;
      roff_d  = '0;
      if (too_long) begin
        rerr_d = RES_TOOLONG;
      end else if (need == '0) begin
        rerr_d = RES_OK;
      end else if (found) begin
        rerr_d  = RES_OK;
        rmask_d = fit_mask;
        roff_d  = OFF_W'(int'(fit_start) * BANK_BYTES);
        busy_d  = busy_freed | fit_mask;
      end else begin
        rerr_d = RES_NOBUF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rv_q   <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmask_q <= '0;
      roff_q  <= '0;
      rerr_q  <= RES_OK;
    end else if (fire) begin
      rmask_q <= rmask_d;
      roff_q  <= roff_d;
      rerr_q  <= rerr_d;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_mask   = rmask_q;
  assign rsp_offset = roff_q;
  assign rsp_err    = rerr_q;
  assign busy_map   = busy_q;
endmodule

// File: rtl/span_bank_alloc_chk.sv
module span_bank_alloc_chk #(
  parameter int TOTAL_BYTES = 4096,
  parameter int NUM_BANKS   = 4,
  parameter int OFF_W       = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_valid,
  input logic                 alloc_ready,
  input logic                 free_valid,
  input logic [NUM_BANKS-1:0] free_mask,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [NUM_BANKS-1:0] rsp_mask,
  input logic [OFF_W-1:0]     rsp_offset,
  input logic [1:0]           rsp_err,
  input logic [NUM_BANKS-1:0] busy_map
);
  localparam int BANK_BYTES = TOTAL_BYTES / NUM_BANKS;

  function automatic logic run_ok(logic [NUM_BANKS-1:0] m);
    logic [NUM_BANKS:0] filled;
    filled = {1'b0, m} | ({1'b0, m} - 1'b1);
    return (m == '0) || (((filled + 1'b1) & {1'b0, m}) == '0);
  endfunction

  function automatic int low_idx(logic [NUM_BANKS-1:0] m);
    int r;
    r = 0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  // R9
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |=> rsp_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_mask) && $stable(rsp_err));

  // R9
  no_accept_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !alloc_ready);

  // R4
  adjacent_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> run_ok(rsp_mask));

  // R5
  err_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err != 2'd0 |-> rsp_mask == '0);

  // R6
  offset_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_mask != '0 |-> int'(rsp_offset) == low_idx(rsp_mask) * BANK_BYTES);

  // R7
  free_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && !(alloc_valid && alloc_ready) |=>
      busy_map == ($past(busy_map) & ~$past(free_mask)));
endmodule

bind span_bank_alloc span_bank_alloc_chk #(
  .TOTAL_BYTES(TOTAL_BYTES), .NUM_BANKS(NUM_BANKS), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .free_valid(free_valid), .free_mask(free_mask), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_mask(rsp_mask), .rsp_offset(rsp_offset),
  .rsp_err(rsp_err), .busy_map(busy_map)
);

// File: tb/span_bank_alloc_tb.sv
module span_bank_alloc_tb;
  logic        clk, rst_n;
  logic        alloc_valid, alloc_ready, free_valid, rsp_valid, rsp_ready;
  logic [15:0] alloc_len;
  logic [3:0]  free_mask, rsp_mask, busy_map;
  logic [11:0] rsp_offset;
  logic [1:0]  rsp_err;
  int n_chk, n_fail;

  span_bank_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_len(alloc_len), .free_valid(free_valid), .free_mask(free_mask),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_mask(rsp_mask),
    .rsp_offset(rsp_offset), .rsp_err(rsp_err), .busy_map(busy_map)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        fv;
    logic [3:0]  fm;
    logic [15:0] len;
    logic [3:0]  em;
    logic [11:0] eo;
    logic [1:0]  ee;
    logic [3:0]  eb;
  } vec_t;

  // bank size 1024 bytes; err 0 ok, 1 no buffer, 2 length error
  localparam vec_t VECS [11] = '{
    '{1'b0, 4'h0, 16'd1000, 4'b0001, 12'd0,    2'd0, 4'b0001}, // R4 one bank
    '{1'b0, 4'h0, 16'd2048, 4'b0110, 12'd1024, 2'd0, 4'b0111}, // R4 R6 two banks
    '{1'b0, 4'h0, 16'd1025, 4'b0000, 12'd0,    2'd1, 4'b0111}, // R5 no run
    '{1'b1, 4'h2, 16'd1,    4'b0010, 12'd1024, 2'd0, 4'b0111}, // R8 reuse freed
    '{1'b0, 4'h0, 16'd5000, 4'b0000, 12'd0,    2'd2, 4'b0111}, // R2 too long
    '{1'b0, 4'h0, 16'd0,    4'b0000, 12'd0,    2'd0, 4'b0111}, // R3 zero length
    '{1'b1, 4'h7, 16'd4096, 4'b1111, 12'd0,    2'd0, 4'b1111}, // R8 R10 full
    '{1'b0, 4'h0, 16'd1,    4'b0000, 12'd0,    2'd1, 4'b1111}, // R5 full map
    '{1'b1, 4'h9, 16'd1024, 4'b0001, 12'd0,    2'd0, 4'b0111}, // R4 lowest start
    '{1'b1, 4'h3, 16'd3000, 4'b0000, 12'd0,    2'd1, 4'b0100}, // R5 gap blocks
    '{1'b1, 4'h4, 16'd3073, 4'b1111, 12'd0,    2'd0, 4'b1111}  // R4 just over 3 banks
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_len = '0;
    free_valid = 1'b0; free_mask = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy_map), 32'h0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R1 ready", 32'(alloc_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      alloc_valid = 1'b1; alloc_len = VECS[i].len;
      free_valid = VECS[i].fv; free_mask = VECS[i].fm;
      @(negedge clk);
      alloc_valid = 1'b0; free_valid = 1'b0; free_mask = '0;
      chk($sformatf("R9 valid v%0d", i), 32'(rsp_valid), 32'h1);
      chk($sformatf("R4 mask v%0d", i), 32'(rsp_mask), 32'(VECS[i].em));
      chk($sformatf("R6 offset v%0d", i), 32'(rsp_offset), 32'(VECS[i].eo));
      chk($sformatf("R10 err v%0d", i), 32'(rsp_err), 32'(VECS[i].ee));
      chk($sformatf("R7 busy v%0d", i), 32'(busy_map), 32'(VECS[i].eb));
    end

    // R7 free alone, then zero mask
    free_valid = 1'b1; free_mask = 4'b0011;
    @(negedge clk);
    chk("R7 partial free", 32'(busy_map), 32'b1100);
    chk("R9 rsp drops", 32'(rsp_valid), 32'h0);
    free_mask = 4'b0000;
    @(negedge clk);
    free_valid = 1'b0;
    chk("R7 zero mask", 32'(busy_map), 32'b1100);

    // R9 backpressure
    rsp_ready = 1'b0; alloc_valid = 1'b1; alloc_len = 16'd10;
    @(negedge clk);
    chk("R9 held valid", 32'(rsp_valid), 32'h1);
    chk("R9 grant", 32'(rsp_mask), 32'b0001);
    chk("R9 not ready", 32'(alloc_ready), 32'h0);
    alloc_len = 16'd2000;
    @(negedge clk);
    chk("R9 not taken busy", 32'(busy_map), 32'b1101);
    chk("R9 stable mask", 32'(rsp_mask), 32'b0001);
    alloc_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", 32'(rsp_valid), 32'h0);
    chk("R9 ready again", 32'(alloc_ready), 32'h1);

    // R1 reset mid-run clears the map
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset busy", 32'(busy_map), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule